// File: doc/BRIEF.md
# Byte-Wide Stored-Program Processor Core

This block is a small von Neumann processor. Program and data live in one 256-byte memory, which the core reaches through a single synchronous port. The port has an address, write data, read data and a write enable, and read data returns one cycle after the address. Each 16-bit instruction takes two neighbouring bytes. The byte at the lower address is the high half. The top nibble is the op-code. The remaining twelve bits are split into fields f1 (bits 11:8), f2 (bits 7:4) and f3 (bits 3:0). Bits 7:0 are also used as the byte operand aa.

The core runs a fixed state machine. FETCH_HI puts the program counter on the address bus. FETCH_LO latches the high byte and presents pc+1. DECODE latches the low byte and advances the program counter by two. EXECUTE performs the instruction. Loads from memory add one more state, LOAD_WB, which writes the returned byte into a register. Halt moves the core into HALTED, which only reset leaves.

The transitions are:
- FETCH_HI to FETCH_LO.
- FETCH_LO to DECODE.
- DECODE to EXECUTE.
- EXECUTE to HALTED on halt.
- EXECUTE to LOAD_WB on either memory load.
- EXECUTE to FETCH_HI for every other op-code.
- LOAD_WB to FETCH_HI.
- HALTED to itself.

Sixteen 8-bit registers R0..RF hold operands. Both conditional jumps compare a named register against R0.

Top module: `byte_cpu`

## Requirements
- R1: While rst_n is low, the program counter takes start_addr, all sixteen registers clear to zero and the state is FETCH_HI. In the first cycle after release, mem_addr equals start_addr, mem_we is low and halted is low.
- R2: An instruction is read as byte pc (its high half) and then byte pc+1. The next instruction starts at pc+2. All address arithmetic wraps modulo 256.
- R3: Op 0x2 (r, aa) loads the constant aa into R[r]. Op 0x1 (r, aa) loads memory cell aa into R[r]. Op 0x6 (d in f1, a in f2) loads the cell addressed by R[a] into R[d].
- R4: Op 0x3 (s in f1, aa) writes R[s] into cell aa. Op 0xD (s in f1, a in f2) writes R[s] into the cell addressed by R[a]. A write asserts mem_we for exactly one cycle.
- R5: Op 0x4 (d in f1, s in f2) copies R[s] into R[d].
- R6: Op 0x5 (d, s, t in f1, f2, f3) writes R[s]+R[t] modulo 256 into R[d].
- R7: Ops 0x7, 0x8 and 0x9 use the d, s, t layout of R6 and write the bitwise OR, AND and XOR of R[s] and R[t] into R[d].
- R8: Op 0xA (r in f1, n in f3) rotates R[r] right by n modulo 8 places.
- R9: Op 0xB (r in f1, aa) loads aa into the program counter when R[r] equals R0. With r=0 the jump is unconditional.
- R10: Op 0xE (r in f1, aa) loads aa into the program counter when R[r] is at most R0, compared as unsigned bytes.
- R11: Op 0xC raises halted. After that, mem_we stays low, halted stays high and mem_addr holds still until reset.
- R12: Ops 0x0 and 0xF change no register and no memory cell. Fetching continues at the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_addr | input | 8 | Address of the first instruction after reset |
| mem_addr | output | 8 | Memory address for a read or a write |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| halted | output | 1 | High once a halt has executed |

## Verification
The bench starts a program at 0xFF so that instruction fetch must wrap to 0x00. A core that kept a ninth address bit, or fetched in the wrong byte order, would then run garbage or never halt. It sets R0 to 0x7F against a register holding 0x80 and against an equal value. A signed compare in the less-or-equal jump would take the wrong path, and an off-by-one would miss the equal case. It uses rotate counts of 0 and 9 and an add that overflows, catching a count that is not reduced modulo 8 and a sum that is not truncated. It places a store right after halt and unassigned op-codes whose fields look like a write, so a core that kept executing or decoded those op-codes would change a memory cell the bench inspects.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP_0   = 4'h0,
        OP_LD_DIR  = 4'h1,
        OP_LD_IMM  = 4'h2,
        OP_ST_DIR  = 4'h3,
        OP_MOVE    = 4'h4,
        OP_ADD     = 4'h5,
        OP_LD_IND  = 4'h6,
        OP_OR      = 4'h7,
        OP_AND     = 4'h8,
        OP_XOR     = 4'h9,
        OP_ROR     = 4'hA,
        OP_JMP_EQ  = 4'hB,
        OP_HALT    = 4'hC,
        OP_ST_IND  = 4'hD,
        OP_JMP_LE  = 4'hE,
        OP_NOP_F   = 4'hF
    } opcode_t;

    typedef enum logic [2:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_EXECUTE,
        ST_LOAD_WB,
        ST_HALTED
    } cpu_state_t;

    typedef enum logic [1:0] {
        WB_ALU,
        WB_IMM,
        WB_MEM
    } wb_src_t;

endpackage

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
    parameter int WIDTH = 8,
    parameter int COUNT = 16,
    localparam int SEL_W = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SEL_W-1:0] rsel_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [SEL_W-1:0] rsel_b,
    output logic [WIDTH-1:0] rdata_b
);

    logic [WIDTH-1:0] regs [COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < COUNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[wsel] <= wdata;
        end
    end

    assign rdata_a = regs[rsel_a];
    assign rdata_b = regs[rsel_b];

endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
    import byte_cpu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int ROT_W = $clog2(WIDTH)
) (
    input  opcode_t          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [ROT_W-1:0] rot,
    output logic [WIDTH-1:0] result,
    output logic             eq,
    output logic             le
);

    logic [2*WIDTH-1:0] doubled;

    always_comb begin
        doubled = {a, a} >> rot;
        unique case (op)
            OP_ADD:  result = a + b;
            OP_OR:   result = a | b;
            OP_AND:  result = a & b;
            OP_XOR:  result = a ^ b;
            OP_ROR:  result = doubled[WIDTH-1:0];
            OP_MOVE: result = a;
            default: result = a;
        endcase
    end

    assign eq = (a == b);
    assign le = (a <= b);

endmodule

// File: rtl/byte_cpu_ctrl.sv
module byte_cpu_ctrl
    import byte_cpu_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 8,
    localparam int INSTR_W = 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic [ADDR_W-1:0]  ind_addr,
    input  logic               take_branch,
    output cpu_state_t         state,
    output logic [INSTR_W-1:0] ir,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic               reg_we,
    output wb_src_t            wb_src,
    output logic               halted
);

    cpu_state_t        state_nx;
    logic [ADDR_W-1:0] pc;
    opcode_t           opc;
    logic [ADDR_W-1:0] imm_addr;
    logic              writes_reg;

    assign opc      = opcode_t'(ir[INSTR_W-1 -: OPC_W]);
    assign imm_addr = ir[ADDR_W-1:0];

    always_comb begin
        unique case (opc)
            OP_LD_IMM, OP_MOVE, OP_ADD, OP_OR,
            OP_AND, OP_XOR, OP_ROR: writes_reg = 1'b1;
            default:                writes_reg = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_HI;
        end else begin
            state <= state_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_HI: state_nx = ST_FETCH_LO;
            ST_FETCH_LO: state_nx = ST_DECODE;
            ST_DECODE:   state_nx = ST_EXECUTE;
            ST_EXECUTE: begin
                if (opc == OP_HALT) begin
                    state_nx = ST_HALTED;
                end else if (opc == OP_LD_DIR || opc == OP_LD_IND) begin
                    state_nx = ST_LOAD_WB;
                end else begin
                    state_nx = ST_FETCH_HI;
                end
            end
            ST_LOAD_WB:  state_nx = ST_FETCH_HI;
            ST_HALTED:   state_nx = ST_HALTED;
            default:     state_nx = ST_FETCH_HI;
        endcase
    end

    // Program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= start_addr;
            ir <= '0;
        end else begin
            unique case (state)
                ST_FETCH_LO: ir[INSTR_W-1 -: WORD_W] <= mem_rdata;
                ST_DECODE: begin
                    ir[WORD_W-1:0] <= mem_rdata;
                    pc             <= pc + ADDR_W'(2);
                end
                ST_EXECUTE: begin
                    if (take_branch) begin
                        pc <= imm_addr;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_addr = pc;
        mem_we   = 1'b0;
        reg_we   = 1'b0;
        wb_src   = WB_ALU;
        halted   = 1'b0;
        unique case (state)
            ST_FETCH_HI: mem_addr = pc;
            ST_FETCH_LO: mem_addr = pc + ADDR_W'(1);
            ST_DECODE:   mem_addr = pc;
            ST_EXECUTE: begin
                unique case (opc)
                    OP_LD_DIR, OP_ST_DIR: mem_addr = imm_addr;
                    OP_LD_IND, OP_ST_IND: mem_addr = ind_addr;
                    default:              mem_addr = pc;
                endcase
                mem_we = (opc == OP_ST_DIR) || (opc == OP_ST_IND);
                reg_we = writes_reg;
                wb_src = (opc == OP_LD_IMM) ? WB_IMM : WB_ALU;
            end
            ST_LOAD_WB: begin
                reg_we = 1'b1;
                wb_src = WB_MEM;
            end
            ST_HALTED:   halted = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
    import byte_cpu_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int REG_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted
);

    localparam int INSTR_W = 2 * WORD_W;
    localparam int SEL_W   = $clog2(REG_COUNT);
    localparam int ROT_W   = $clog2(WORD_W);
    localparam int F1_LSB  = INSTR_W - OPC_W - SEL_W;
    localparam int F2_LSB  = F1_LSB - SEL_W;
    localparam int F3_LSB  = F2_LSB - SEL_W;

    cpu_state_t         cpu_state;
    logic [INSTR_W-1:0] ir;
    opcode_t            opc;
    logic [SEL_W-1:0]   f1, f2, f3;
    logic [SEL_W-1:0]   rsel_a, rsel_b;
    logic [WORD_W-1:0]  rdata_a, rdata_b, alu_res, wdata;
    logic               reg_we, cmp_eq, cmp_le, take_branch;
    wb_src_t            wb_src;

    assign opc = opcode_t'(ir[INSTR_W-1 -: OPC_W]);
    assign f1  = ir[F1_LSB +: SEL_W];
    assign f2  = ir[F2_LSB +: SEL_W];
    assign f3  = ir[F3_LSB +: SEL_W];

    // Read-port selection per op-code
    always_comb begin
        unique case (opc)
            OP_MOVE, OP_ADD, OP_OR, OP_AND, OP_XOR: begin
                rsel_a = f2;
                rsel_b = f3;
            end
            OP_LD_IND, OP_ST_IND: begin
                rsel_a = f1;
                rsel_b = f2;
            end
            OP_JMP_EQ, OP_JMP_LE: begin
                rsel_a = f1;
                rsel_b = '0;
            end
            default: begin
                rsel_a = f1;
                rsel_b = f3;
            end
        endcase
    end

    always_comb begin
        unique case (wb_src)
            WB_IMM:  wdata = ir[WORD_W-1:0];
            WB_MEM:  wdata = mem_rdata;
            default: wdata = alu_res;
        endcase
    end

    assign take_branch = (cpu_state == ST_EXECUTE) &&
                         ((opc == OP_JMP_EQ && cmp_eq) ||
                          (opc == OP_JMP_LE && cmp_le));
    assign mem_wdata = rdata_a;

    byte_cpu_regfile #(
        .WIDTH (WORD_W),
        .COUNT (REG_COUNT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .wsel    (f1),
        .wdata   (wdata),
        .rsel_a  (rsel_a),
        .rdata_a (rdata_a),
        .rsel_b  (rsel_b),
        .rdata_b (rdata_b)
    );

    byte_cpu_alu #(
        .WIDTH (WORD_W)
    ) u_alu (
        .op     (opc),
        .a      (rdata_a),
        .b      (rdata_b),
        .rot    (f3[ROT_W-1:0]),
        .result (alu_res),
        .eq     (cmp_eq),
        .le     (cmp_le)
    );

    byte_cpu_ctrl #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_addr  (start_addr),
        .mem_rdata   (mem_rdata),
        .ind_addr    (rdata_b[ADDR_W-1:0]),
        .take_branch (take_branch),
        .state       (cpu_state),
        .ir          (ir),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .reg_we      (reg_we),
        .wb_src      (wb_src),
        .halted      (halted)
    );

endmodule

// File: rtl/byte_cpu_checker.sv
module byte_cpu_checker
    import byte_cpu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input cpu_state_t        state
);

    logic first_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_cyc <= 1'b1;
        end else begin
            first_cyc <= 1'b0;
        end
    end

    assert_reset_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_cyc |-> (mem_addr == start_addr && !mem_we && !halted));

    assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_HI) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1)));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_halt_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr)));

endmodule

bind byte_cpu byte_cpu_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_addr (start_addr),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .halted     (halted),
    .state      (cpu_state)
);

// File: tb/byte_cpu_tb_top.sv
`timescale 1ns/1ps
module byte_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] start_addr = 8'h00;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, halted;
    logic [7:0] mem [256];
    logic [7:0] ptr;
    int         n_checks = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    byte_cpu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .halted     (halted)
    );

    function automatic logic [15:0] i3(input logic [3:0] op, a, b, c);
        return {op, a, b, c};
    endfunction

    function automatic logic [15:0] ib(input logic [3:0] op, r, input logic [7:0] v);
        return {op, r, v};
    endfunction

    function automatic logic [7:0] exp_ror(input logic [7:0] v, input logic [3:0] n);
        logic [7:0] r = v;
        for (int k = 0; k < (n % 8); k++) r = {r[0], r[7:1]};
        return r;
    endfunction

    task automatic emit(input logic [15:0] w);
        mem[ptr] = w[15:8];
        mem[8'(ptr + 1)] = w[7:0];
        ptr = 8'(ptr + 2);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic begin_prog(input logic [7:0] sa);
        @(negedge clk);
        rst_n = 1'b0;
        start_addr = sa;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        ptr = sa;
    endtask

    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 first address", mem_addr, start_addr);
        chk("R1 write enable low", {7'd0, mem_we}, 8'h00);
        chk("R1 halted low", {7'd0, halted}, 8'h00);
    endtask

    task automatic run_to_halt();
        int cnt = 0;
        while (!halted && cnt < 3000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R11 halt reached", {7'd0, halted}, 8'h01);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_sim();
    end

    initial begin
        logic [7:0] a0, x, y, rr, tgt;
        logic [3:0] n;
        void'($urandom(32'd2024));

        // Directed: fetch wraps from 0xFF to 0x00, op 0x0 is a no-op (R2, R12)
        begin_prog(8'hFF);
        emit(16'h0000);
        emit(16'hC000);
        release_reset();
        @(negedge clk); #1;
        chk("R2 low byte address wraps", mem_addr, 8'h00);
        repeat (3) @(negedge clk); #1;
        chk("R2 next instruction at pc+2", mem_addr, 8'h01);
        run_to_halt();

        // Directed: loads, jumps, no-ops, add wrap, rotate, halt freeze
        begin_prog(8'h10);
        mem[8'hE0] = 8'hAA;
        mem[8'hC0] = 8'h80;
        emit(ib(4'h3, 4'h7, 8'hE0));
        emit(ib(4'h1, 4'h1, 8'hC0));
        emit(ib(4'h2, 4'h0, 8'h7F));
        emit(ib(4'h2, 4'h2, 8'h55));
        tgt = 8'(ptr + 4); emit(ib(4'hE, 4'h1, tgt)); emit(ib(4'h3, 4'h2, 8'hE1));
        tgt = 8'(ptr + 4); emit(ib(4'hE, 4'h0, tgt)); emit(ib(4'h3, 4'h2, 8'hE2));
        tgt = 8'(ptr + 4); emit(ib(4'hB, 4'h0, tgt)); emit(ib(4'h3, 4'h2, 8'hE3));
        emit(ib(4'h2, 4'h3, 8'h7E));
        tgt = 8'(ptr + 4); emit(ib(4'hB, 4'h3, tgt)); emit(ib(4'h3, 4'h2, 8'hE4));
        emit(16'hF3FF);
        emit(16'h03E6);
        emit(ib(4'h3, 4'h3, 8'hE5));
        emit(ib(4'h2, 4'h4, 8'hF0));
        emit(ib(4'h2, 4'h5, 8'h20));
        emit(i3(4'h5, 4'h6, 4'h4, 4'h5));
        emit(ib(4'h3, 4'h6, 8'hE7));
        emit(ib(4'h2, 4'h8, 8'h81));
        emit(i3(4'hA, 4'h8, 4'h0, 4'h0));
        emit(ib(4'h3, 4'h8, 8'hE8));
        emit(i3(4'hA, 4'h8, 4'h0, 4'h9));
        emit(ib(4'h3, 4'h8, 8'hE9));
        emit(16'hC000);
        emit(ib(4'h3, 4'h2, 8'hEA));
        release_reset();
        run_to_halt();
        chk("R1 registers cleared", mem[8'hE0], 8'h00);
        chk("R10 unsigned 0x80>0x7F not taken", mem[8'hE1], 8'h55);
        chk("R10 equal taken", mem[8'hE2], 8'h00);
        chk("R9 unconditional via R0", mem[8'hE3], 8'h00);
        chk("R9 unequal not taken", mem[8'hE4], 8'h55);
        chk("R12 op F leaves register", mem[8'hE5], 8'h7E);
        chk("R12 op 0 leaves memory", mem[8'hE6], 8'h00);
        chk("R6 add wraps", mem[8'hE7], 8'h10);
        chk("R8 rotate by 0", mem[8'hE8], 8'h81);
        chk("R8 rotate by 9", mem[8'hE9], 8'hC0);
        a0 = mem_addr;
        begin
            int bad = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk); #1;
                if (mem_we || !halted || mem_addr !== a0) bad++;
            end
            chk("R11 frozen after halt", 8'(bad), 8'h00);
        end
        chk("R11 store after halt skipped", mem[8'hEA], 8'h00);

        // Random rounds: R3..R8, R10
        for (int rnd = 0; rnd < 12; rnd++) begin
            x = 8'($urandom);
            y = 8'($urandom);
            n = 4'($urandom);
            rr = exp_ror(x, n);
            if (rnd % 3 == 0) y = rr;
            else if (rnd % 3 == 1) y = 8'(rr - 1);
            begin_prog(8'($urandom_range(0, 8'h9F)));
            emit(ib(4'h2, 4'h1, x));
            emit(ib(4'h2, 4'h2, y));
            emit(i3(4'h5, 4'h3, 4'h1, 4'h2));
            emit(i3(4'h8, 4'h4, 4'h1, 4'h2));
            emit(i3(4'h7, 4'h5, 4'h1, 4'h2));
            emit(i3(4'h9, 4'h6, 4'h1, 4'h2));
            emit(i3(4'hA, 4'h1, 4'h0, n));
            emit(i3(4'h4, 4'h7, 4'h1, 4'h0));
            emit(ib(4'h3, 4'h3, 8'hF0));
            emit(ib(4'h3, 4'h4, 8'hF1));
            emit(ib(4'h3, 4'h5, 8'hF2));
            emit(ib(4'h3, 4'h6, 8'hF3));
            emit(ib(4'h3, 4'h7, 8'hF4));
            emit(ib(4'h2, 4'h8, 8'hF5));
            emit(i3(4'hD, 4'h2, 4'h8, 4'h0));
            emit(i3(4'h6, 4'h9, 4'h8, 4'h0));
            emit(ib(4'h3, 4'h9, 8'hF6));
            emit(ib(4'h2, 4'h0, y));
            emit(ib(4'h2, 4'hA, 8'h5A));
            tgt = 8'(ptr + 4); emit(ib(4'hE, 4'h1, tgt)); emit(ib(4'h3, 4'hA, 8'hF7));
            emit(16'hC000);
            release_reset();
            run_to_halt();
            chk("R6 add", mem[8'hF0], 8'(x + y));
            chk("R7 and", mem[8'hF1], x & y);
            chk("R7 or", mem[8'hF2], x | y);
            chk("R7 xor", mem[8'hF3], x ^ y);
            chk("R5 R8 move of rotated", mem[8'hF4], rr);
            chk("R4 indirect store", mem[8'hF5], y);
            chk("R3 indirect load", mem[8'hF6], y);
            chk("R10 jump le", mem[8'hF7], (rr <= y) ? 8'h00 : 8'h5A);
        end

        finish_sim();
    end

endmodule